// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Two Alarms

This block is a memory-mapped real-time clock for a chip's peripheral area. A free-running seconds counter advances once per second, using a prescaler that divides the system clock. Two alarm channels each compare a stored value against the counter. On a match an alarm channel raises a sticky status flag. Each channel can also raise a periodic flag, either once per second or at a faster rate taken from a second prescaler. One interrupt line per channel is driven from the channel's flags and its enable bits. Software acknowledges a flag by writing a one to its status bit.

A simple single-cycle register port provides access. Writes are accepted in the cycle they are presented and never stall the bus. They are held in a one-entry settling stage and reach the registers only after a fixed interval, given as a parameter in system clock cycles. If a second write arrives while one is still settling, the older write is flushed into the registers at once. The new write then starts its own interval. Reads are returned one cycle after they are requested.

Top module: `rtc_secs_core`

## Requirements
- R1: After reset every mapped register reads zero and both interrupt outputs are low.
- R2: The seconds count (offset 0x0C) increments by one exactly once every TICK_DIV clock cycles and holds between increments.
- R3: A write accepted at clock edge E changes the addressed register at edge E+SETTLE_CYC; a read whose capture edge is at or before that edge returns the old value.
- R4: A write accepted while an earlier write is still settling commits the earlier write on that same edge; the new write then commits SETTLE_CYC edges after its own acceptance.
- R5: Committing a write to offset 0x0C loads the count and restarts the prescaler, so the next increment comes TICK_DIV cycles after the commit edge.
- R6: A channel's alarm flag (status bit 0 for channel 1, bit 1 for channel 2) is set on the increment whose new count equals that channel's compare value (offset 0x10 for channel 1, 0x14 for channel 2), and it stays set until acknowledged.
- R7: A committed status write (offset 0x00) clears each flag whose bit is one and leaves flags whose bit is zero unchanged; writing zero has no effect.
- R8: Interrupt output i is high while channel i's alarm flag is set and bit 0 of its configuration register (0x04 for channel 1, 0x08 for channel 2) is one, or while its periodic flag is set and bit 1 is one.
- R9: With configuration bit 1 set, a channel's periodic flag (status bit 2 for channel 1, bit 3 for channel 2) is set on every seconds increment when bit 2 is one and on every SUB_DIV-cycle fast tick when bit 2 is zero.
- R10: Read data appears on the output in the cycle after the read request. Offsets with no register read as zero.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write request, accepted in the same cycle |
| bus_rd_en | input | 1 | Read request, data returned next cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 2 | Interrupt per alarm channel |

## Verification
Each result is due a fixed number of edges after its stimulus. A read captures the state one edge after the request. A write shows up SETTLE_CYC edges after its acceptance edge. A loaded count increments TICK_DIV edges after its commit edge, and the compare hit comes on the increment that produces the compare value. Every bench task starts and ends on a falling edge. It counts idle cycles from the last acceptance or commit edge so that each read captures the exact edge before or after the expected change. Pairs of back-to-back reads then pin each transition to one cycle. The interrupt outputs are combinational from the flags, so they are sampled on a falling edge after the commit that changes them.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int unsigned NUM_CH = 2;

   // register byte offsets
   localparam logic [7:0] OFF_STATUS   = 8'h00;
   localparam logic [7:0] OFF_CFG_BASE = 8'h04;
   localparam logic [7:0] OFF_TIME     = 8'h0C;
   localparam logic [7:0] OFF_CMP_BASE = 8'h10;

   // per-channel configuration: bit2 one_hz, bit1 per_en, bit0 al_en
   typedef struct packed {
      logic one_hz;
      logic per_en;
      logic al_en;
   } ch_cfg_t;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("rtc_prescaler: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   // two ticks are never adjacent
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/rtc_write_settle.sv
module rtc_write_settle #(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SETTLE_CYC = 1250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              commit,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("rtc_write_settle: SETTLE_CYC must be at least 1");
   end

   logic              pend_q;
   logic [CW-1:0]     left_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   // flush early when a newer write arrives
   assign commit      = pend_q && ((left_q == CW'(1)) || wr_en);
   assign commit_addr = addr_q;
   assign commit_data = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         left_q <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else if (wr_en) begin
         pend_q <= 1'b1;
         left_q <= CW'(SETTLE_CYC);
         addr_q <= wr_addr;
         data_q <= wr_data;
      end else if (commit) begin
         pend_q <= 1'b0;
         left_q <= '0;
      end else if (pend_q) begin
         left_q <= left_q - 1'b1;
      end
   end

   assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pend_q && (left_q == CW'(SETTLE_CYC)));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !wr_en && (left_q != CW'(1))) |=>
         pend_q && $stable(addr_q) && $stable(data_q));

   assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pend_q) |-> commit);

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
   import rtc_pkg::*;
#(
   parameter int unsigned TIME_W       = 32,
   parameter bit          HAS_PERIODIC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_evt,
   input  logic              fast_evt,
   input  logic [TIME_W-1:0] secs_next,
   input  logic              cmp_wr,
   input  logic [TIME_W-1:0] cmp_wdata,
   input  logic              cfg_wr,
   input  ch_cfg_t           cfg_wdata,
   input  logic              clr_al,
   input  logic              clr_per,
   output logic [TIME_W-1:0] cmp_val,
   output ch_cfg_t           cfg_val,
   output logic              flag_al,
   output logic              flag_per,
   output logic              irq
);
   logic [TIME_W-1:0] cmp_q;
   ch_cfg_t           cfg_q;
   logic              al_q;
   logic              al_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         cfg_q <= '0;
      end else begin
         if (cmp_wr) cmp_q <= cmp_wdata;
         if (cfg_wr) cfg_q <= cfg_wdata;
      end
   end

   assign al_hit = sec_evt && (secs_next == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) al_q <= 1'b0;
      else        al_q <= al_hit || (al_q && !clr_al);
   end

   if (HAS_PERIODIC) begin : g_per
      logic per_q;
      logic per_hit;
      assign per_hit = cfg_q.per_en && (cfg_q.one_hz ? sec_evt : fast_evt);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) per_q <= 1'b0;
         else        per_q <= per_hit || (per_q && !clr_per);
      end
      assign flag_per = per_q;
   end else begin : g_no_per
      logic unused_per;
      assign unused_per = fast_evt ^ clr_per;
      assign flag_per   = 1'b0;
   end

   assign cmp_val = cmp_q;
   assign cfg_val = cfg_q;
   assign flag_al = al_q;
   assign irq     = (al_q && cfg_q.al_en) || (flag_per && cfg_q.per_en);

   assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_al && !clr_al) |=> flag_al);

   assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_al && !sec_evt) |=> !flag_al);

   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_al || flag_per));

endmodule

// File: rtl/rtc_secs_core.sv
module rtc_secs_core
   import rtc_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned TIME_W       = 32,
   parameter int unsigned TICK_DIV     = 250_000_000,
   parameter int unsigned SUB_DIV      = 250_000,
   parameter int unsigned SETTLE_CYC   = 1250,
   parameter bit          HAS_PERIODIC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq_o
);
   localparam int unsigned STAT_W = 2 * NUM_CH;

   if (TIME_W > DATA_W) begin : g_bad_time_w
      $error("rtc_secs_core: TIME_W exceeds DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("rtc_secs_core: ADDR_W too small for the register map");
   end
   if (DATA_W < STAT_W) begin : g_bad_data_w
      $error("rtc_secs_core: DATA_W too small for status");
   end

   logic              commit;
   logic [ADDR_W-1:0] c_addr;
   logic [DATA_W-1:0] c_data;

   rtc_write_settle #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
   ) u_settle (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr_en), .wr_addr(bus_addr), .wr_data(bus_wdata),
      .commit(commit), .commit_addr(c_addr), .commit_data(c_data)
   );

   logic time_load;
   logic stat_wr;
   logic sec_tick;
   logic fast_tick;
   logic sec_evt;

   assign time_load = commit && (c_addr == ADDR_W'(OFF_TIME));
   assign stat_wr   = commit && (c_addr == ADDR_W'(OFF_STATUS));

   rtc_prescaler #(.DIV(TICK_DIV)) u_sec_div (
      .clk(clk), .rst_n(rst_n), .restart(time_load), .tick(sec_tick)
   );

   rtc_prescaler #(.DIV(SUB_DIV)) u_fast_div (
      .clk(clk), .rst_n(rst_n), .restart(1'b0), .tick(fast_tick)
   );

   // a load wins over an increment on the same edge
   assign sec_evt = sec_tick && !time_load;

   logic [TIME_W-1:0] secs_q;
   logic [TIME_W-1:0] secs_next;

   assign secs_next = secs_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         secs_q <= '0;
      else if (time_load) secs_q <= c_data[TIME_W-1:0];
      else if (sec_evt)   secs_q <= secs_next;
   end

   logic [TIME_W-1:0] cmp_val [NUM_CH];
   ch_cfg_t           cfg_val [NUM_CH];
   logic [NUM_CH-1:0] flag_al;
   logic [NUM_CH-1:0] flag_per;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam logic [7:0] CFG_OFF = OFF_CFG_BASE + 8'(4 * ch);
      localparam logic [7:0] CMP_OFF = OFF_CMP_BASE + 8'(4 * ch);

      logic cfg_wr;
      logic cmp_wr;
      assign cfg_wr = commit && (c_addr == ADDR_W'(CFG_OFF));
      assign cmp_wr = commit && (c_addr == ADDR_W'(CMP_OFF));

      rtc_alarm_unit #(
         .TIME_W(TIME_W), .HAS_PERIODIC(HAS_PERIODIC)
      ) u_ch (
         .clk(clk), .rst_n(rst_n),
         .sec_evt(sec_evt), .fast_evt(fast_tick), .secs_next(secs_next),
         .cmp_wr(cmp_wr), .cmp_wdata(c_data[TIME_W-1:0]),
         .cfg_wr(cfg_wr), .cfg_wdata(ch_cfg_t'(c_data[2:0])),
         .clr_al(stat_wr && c_data[ch]),
         .clr_per(stat_wr && c_data[NUM_CH + ch]),
         .cmp_val(cmp_val[ch]), .cfg_val(cfg_val[ch]),
         .flag_al(flag_al[ch]), .flag_per(flag_per[ch]),
         .irq(irq_o[ch])
      );
   end

   logic [STAT_W-1:0] status;
   logic [DATA_W-1:0] rd_mux;

   assign status = {flag_per, flag_al};

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(OFF_STATUS))
         rd_mux = DATA_W'(status);
      else if (bus_addr == ADDR_W'(OFF_TIME))
         rd_mux = DATA_W'(secs_q);
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (bus_addr == ADDR_W'(OFF_CFG_BASE + 8'(4 * ch)))
            rd_mux = DATA_W'(cfg_val[ch]);
         if (bus_addr == ADDR_W'(OFF_CMP_BASE + 8'(4 * ch)))
            rd_mux = DATA_W'(cmp_val[ch]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_mux;
   end

   assert_secs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !time_load) |=> $stable(secs_q));

   assert_time_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      time_load |=> (secs_q == $past(c_data[TIME_W-1:0])));

   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/rtc_secs_core_tb_top.sv
module rtc_secs_core_tb_top;

   localparam int unsigned DW  = 32;
   localparam int unsigned AW  = 5;
   localparam int unsigned DIV = 40;
   localparam int unsigned SUB = 8;
   localparam int unsigned S   = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [1:0]    irq;

   int n_checks = 0;
   int n_bad    = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   rtc_secs_core #(
      .DATA_W(DW), .ADDR_W(AW), .TIME_W(32),
      .TICK_DIV(DIV), .SUB_DIV(SUB), .SETTLE_CYC(S), .HAS_PERIODIC(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_en(wr_en), .bus_rd_en(rd_en), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all bus tasks start and end just after a falling edge
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a[AW-1:0]; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a[AW-1:0];
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic load_time(input logic [31:0] t);
      wr(8'h0C, t);
      idle(S);          // now just after the commit edge
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int a = 0; a < 6; a++) begin
         rd(8'(4 * a), v);
         chk("R1 reset register value", v, 32'h0);
      end
      chk("R1 irq after reset", 32'(irq), 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(8'h18, v); chk("R10 unmapped 0x18", v, 32'h0);
      rd(8'h1C, v); chk("R10 unmapped 0x1C", v, 32'h0);
   endtask

   task automatic t_settle();
      logic [31:0] v;
      wr(8'h10, 32'hA5A5_0123);
      idle(S - 1);
      rd(8'h10, v); chk("R3 old value before settle", v, 32'h0);
      rd(8'h10, v); chk("R3 new value after settle", v, 32'hA5A5_0123);
   endtask

   task automatic t_flush();
      logic [31:0] v;
      wr(8'h14, 32'h0000_1111);
      wr(8'h14, 32'h0000_2222);
      rd(8'h14, v); chk("R4 first write flushed", v, 32'h0000_1111);
      idle(S - 2);
      rd(8'h14, v); chk("R4 second write still settling", v, 32'h0000_1111);
      rd(8'h14, v); chk("R4 second write committed", v, 32'h0000_2222);
   endtask

   task automatic t_count();
      logic [31:0] v;
      load_time(32'h0000_1000);
      rd(8'h0C, v); chk("R5 loaded count", v, 32'h0000_1000);
      idle(DIV - 2);
      rd(8'h0C, v); chk("R2 count holds until tick", v, 32'h0000_1000);
      rd(8'h0C, v); chk("R2 R5 increment after TICK_DIV", v, 32'h0000_1001);
   endtask

   task automatic t_alarm();
      logic [31:0] v;
      wr(8'h10, 32'd100);
      idle(S);
      load_time(32'd98);
      idle(2 * DIV - 1);
      rd(8'h00, v); chk("R6 no flag before match", v, 32'h0);
      rd(8'h00, v); chk("R6 alarm flag on match", v, 32'h1);
      chk("R8 irq low with enable clear", 32'(irq), 32'h0);
      wr(8'h04, 32'h1);
      idle(S);
      chk("R8 irq high with enable set", 32'(irq), 32'h1);
      idle(DIV);
      rd(8'h00, v); chk("R6 flag stays set", v, 32'h1);
      wr(8'h00, 32'h0);
      idle(S);
      rd(8'h00, v); chk("R7 zero write has no effect", v, 32'h1);
      wr(8'h00, 32'h1);
      idle(S);
      rd(8'h00, v); chk("R7 write one clears flag", v, 32'h0);
      chk("R7 R8 irq low after clear", 32'(irq), 32'h0);
   endtask

   task automatic t_periodic_1hz();
      logic [31:0] v;
      wr(8'h08, 32'h6);
      idle(S);
      load_time(32'd500);
      wr(8'h00, 32'h8);
      idle(DIV - 2);
      rd(8'h00, v); chk("R9 no 1Hz flag before tick", v, 32'h0);
      rd(8'h00, v); chk("R9 1Hz flag on channel 2", v, 32'h8);
      chk("R8 channel 2 periodic irq", 32'(irq), 32'h2);
      wr(8'h08, 32'h0);
      wr(8'h00, 32'h8);
      idle(S);
      rd(8'h00, v); chk("R9 R7 periodic flag cleared", v, 32'h0);
      chk("R8 irq low after disable", 32'(irq), 32'h0);
   endtask

   task automatic t_periodic_fast();
      logic [31:0] v;
      wr(8'h04, 32'h2);
      idle(S + SUB + 1);
      rd(8'h04, v); chk("R9 config readback", v, 32'h2);
      rd(8'h00, v); chk("R9 fast periodic flag on channel 1", v, 32'h4);
      chk("R8 channel 1 periodic irq", 32'(irq), 32'h1);
      wr(8'h04, 32'h0);
      wr(8'h00, 32'h4);
      idle(S);
      rd(8'h00, v); chk("R9 R7 fast flag cleared", v, 32'h0);
      chk("R8 irq low at end", 32'(irq), 32'h0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_unmapped();
      t_settle();
      t_flush();
      t_count();
      t_alarm();
      t_periodic_1hz();
      t_periodic_fast();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

endmodule